// File: doc/BRIEF.md
# Receive Interrupt Mitigation Unit

This block decides when an Ethernet MAC raises its receive-interrupt status bit. Without it, every completed frame would interrupt the host. With it, the interrupt waits until one of two conditions is met: a programmed number of frames has arrived, or a programmed idle time has passed since the most recent frame. The idle time is counted in units of an external tick pulse.

Software writes a timer field and a packet-count field together. The block keeps a programmed copy and a live copy of each field. The live copies are what software reads back. Writing zero to a field takes that condition out of the decision. When both fields are zero, every frame interrupts at once.

The output is a set pulse for the status bit. The status bit itself, its clear path, and the rest of the interrupt logic live elsewhere.

Top module: `rx_irq_mitigator`

## Requirements
- R1: After reset, `irq_set` is 0, both live values read 0, and both programmed values are 0, which means mitigation is off.
- R2: A cycle with `cfg_we`=1 loads the programmed and live copies of both fields from `cfg_tmr`/`cfg_cnt`, stops the timer, and keeps `irq_set` at 0. In that cycle, `frame_done` and `unit_tick` are discarded. The new values are visible on `tmr_live`/`cnt_live` in the next cycle.
- R3: With a nonzero programmed count, each accepted `frame_done` lowers `cnt_live` by one.
- R4: When a frame arrives while `cnt_live` is 1, `irq_set` is 1 in the following cycle and `cnt_live` returns to the programmed count.
- R5: With both programmed fields zero, every accepted `frame_done` gives `irq_set`=1 in the following cycle, and the live values stay 0.
- R6: With a nonzero programmed timer, every accepted frame reloads `tmr_live` with the programmed value and starts the timer. This applies even if the timer is already running.
- R7: While the timer runs, each `unit_tick` lowers `tmr_live` by one. A tick that arrives while `tmr_live` is 1 gives `irq_set`=1 in the following cycle.
- R8: After any interrupt, both live values return to their programmed values and the timer stops. Ticks then change nothing until the next frame arrives.
- R9: When `frame_done` and `unit_tick` are high in the same cycle, the frame is handled and the tick is discarded.
- R10: `irq_set` is high only in the cycle after an accepted frame or tick. All outputs are registered and change on the edge that samples the cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle pulse per received frame |
| unit_tick | input | 1 | One-cycle pulse per timeout unit |
| cfg_we | input | 1 | Register write strobe for both fields |
| cfg_tmr | input | TMR_W (4) | Timer field write value |
| cfg_cnt | input | CNT_W (3) | Packet-count field write value |
| irq_set | output | 1 | Pulse that sets the receive-interrupt status bit |
| tmr_live | output | TMR_W (4) | Live timer value |
| cnt_live | output | CNT_W (3) | Live packet counter value |

## Verification
The checker assumes the following about the inputs:
- `frame_done` and `unit_tick` are synchronous single-cycle strobes.
- A write changes both fields at once.

The checker tracks the programmed fields from the write strobe. It then bounds the live values by them and checks the zero-field bypass. The stimulus changes inputs only on the falling clock edge and writes only through `cfg_we`. It covers frames, ticks, writes during a running countdown, and a frame coinciding with a tick.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_DIRECT = 2'd1,
      SRC_COUNT  = 2'd2,
      SRC_TIMER  = 2'd3
   } fire_src_e;
endpackage

// File: rtl/rxm_pkt_counter.sv
module rxm_pkt_counter #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wr_val,
   input  logic         dec,
   input  logic         reload,
   output logic [W-1:0] live,
   output logic         hit,
   output logic         off
);
   logic [W-1:0] prog_q;
   logic [W-1:0] live_q;

   // live is 1 only when the programmed value is nonzero
   assign hit  = dec && (live_q == W'(1));
   assign off  = (prog_q == '0);
   assign live = live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= '0;
         live_q <= '0;
      end else if (wr) begin
         prog_q <= wr_val;
         live_q <= wr_val;
      end else if (reload) begin
         live_q <= prog_q;
      end else if (dec && (live_q != '0)) begin
         live_q <= live_q - W'(1);
      end
   end
endmodule

// File: rtl/rxm_idle_timer.sv
module rxm_idle_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wr_val,
   input  logic         arm,
   input  logic         tick,
   input  logic         reload,
   output logic [W-1:0] live,
   output logic         hit,
   output logic         off
);
   logic [W-1:0] prog_q;
   logic [W-1:0] live_q;
   logic         run_q;

   assign hit  = tick && run_q && (live_q == W'(1));
   assign off  = (prog_q == '0);
   assign live = live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= '0;
         live_q <= '0;
         run_q  <= 1'b0;
      end else if (wr) begin
         prog_q <= wr_val;
         live_q <= wr_val;
         run_q  <= 1'b0;
      end else if (reload) begin
         live_q <= prog_q;
         run_q  <= 1'b0;
      end else if (arm && !off) begin
         live_q <= prog_q;
         run_q  <= 1'b1;
      end else if (tick && run_q) begin
         live_q <= live_q - W'(1);
      end
   end
endmodule

// File: rtl/rxm_fire_ctrl.sv
module rxm_fire_ctrl
   import rxm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_ok,
   input  logic cnt_hit,
   input  logic tmr_hit,
   input  logic cnt_off,
   input  logic tmr_off,
   output logic fire,
   output logic irq_q
);
   fire_src_e src;

   always_comb begin
      if (frame_ok && cnt_off && tmr_off) src = SRC_DIRECT;
      else if (cnt_hit)                   src = SRC_COUNT;
      else if (tmr_hit)                   src = SRC_TIMER;
      else                                src = SRC_NONE;
   end

   assign fire = (src != SRC_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= fire;
   end
endmodule

// File: rtl/rx_irq_mitigator.sv
module rx_irq_mitigator #(
   parameter int TMR_W = 4,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_done,
   input  logic             unit_tick,
   input  logic             cfg_we,
   input  logic [TMR_W-1:0] cfg_tmr,
   input  logic [CNT_W-1:0] cfg_cnt,
   output logic             irq_set,
   output logic [TMR_W-1:0] tmr_live,
   output logic [CNT_W-1:0] cnt_live
);
   localparam int MAX_W = 16;

   generate
      if (TMR_W < 1 || TMR_W > MAX_W) begin : g_bad_tmr
         $error("rx_irq_mitigator: TMR_W out of range");
      end
      if (CNT_W < 1 || CNT_W > MAX_W) begin : g_bad_cnt
         $error("rx_irq_mitigator: CNT_W out of range");
      end
   endgenerate

   logic frame_ok, tick_ok;
   logic cnt_hit, tmr_hit, cnt_off, tmr_off, fire;

   // write wins over events; frame wins over tick
   assign frame_ok = frame_done && !cfg_we;
   assign tick_ok  = unit_tick && !cfg_we && !frame_done;

   rxm_pkt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr(cfg_we), .wr_val(cfg_cnt),
      .dec(frame_ok), .reload(fire), .live(cnt_live),
      .hit(cnt_hit), .off(cnt_off)
   );

   rxm_idle_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .wr(cfg_we), .wr_val(cfg_tmr),
      .arm(frame_ok), .tick(tick_ok), .reload(fire), .live(tmr_live),
      .hit(tmr_hit), .off(tmr_off)
   );

   rxm_fire_ctrl u_fire (
      .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
      .cnt_hit(cnt_hit), .tmr_hit(tmr_hit),
      .cnt_off(cnt_off), .tmr_off(tmr_off),
      .fire(fire), .irq_q(irq_set)
   );
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
   parameter int TMR_W = 4,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_done,
   input logic             unit_tick,
   input logic             cfg_we,
   input logic [TMR_W-1:0] cfg_tmr,
   input logic [CNT_W-1:0] cfg_cnt,
   input logic             irq_set,
   input logic [TMR_W-1:0] tmr_live,
   input logic [CNT_W-1:0] cnt_live
);
   logic [TMR_W-1:0] sh_t;
   logic [CNT_W-1:0] sh_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_t <= '0;
         sh_c <= '0;
      end else if (cfg_we) begin
         sh_t <= cfg_tmr;
         sh_c <= cfg_cnt;
      end
   end

   // R10
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |-> $past(!cfg_we && (frame_done || unit_tick)));

   // R2
   write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (tmr_live == $past(cfg_tmr) && cnt_live == $past(cfg_cnt) && !irq_set));

   // R5
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !cfg_we && sh_t == '0 && sh_c == '0) |=> irq_set);

   // R3
   live_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_live <= sh_c) && (tmr_live <= sh_t));

   // R8
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !cfg_we) |=> ($stable(cnt_live) || irq_set));

   // R7
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !unit_tick && !cfg_we) |=> $stable(tmr_live));
endmodule

bind rx_irq_mitigator rxm_checker #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_rxm_chk (
   .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .unit_tick(unit_tick),
   .cfg_we(cfg_we), .cfg_tmr(cfg_tmr), .cfg_cnt(cfg_cnt),
   .irq_set(irq_set), .tmr_live(tmr_live), .cnt_live(cnt_live)
);

// File: tb/test_rx_irq_mitigator.sv
`timescale 1ns/1ps
module test_rx_irq_mitigator;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_done = 1'b0, unit_tick = 1'b0, cfg_we = 1'b0;
   logic [3:0] cfg_tmr = '0;
   logic [2:0] cfg_cnt = '0;
   logic       irq_set;
   logic [3:0] tmr_live;
   logic [2:0] cnt_live;

   int n_run = 0, n_fail = 0;

   typedef struct {
      logic       irq;
      logic [3:0] tmr;
      logic [2:0] cnt;
      string      tag;
   } exp_t;
   exp_t sb[$];

   logic [3:0] m_pt = '0, m_t = '0;
   logic [2:0] m_pc = '0, m_c = '0;
   logic       m_run = 1'b0;

   always #5 clk = ~clk;

   rx_irq_mitigator i_rx_irq_mitigator (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .unit_tick(unit_tick),
      .cfg_we(cfg_we), .cfg_tmr(cfg_tmr), .cfg_cnt(cfg_cnt),
      .irq_set(irq_set), .tmr_live(tmr_live), .cnt_live(cnt_live)
   );

   // driver: one cycle of stimulus plus the expected result from the requirements
   task automatic drive(input logic we, input logic [3:0] t, input logic [2:0] c,
                        input logic f, input logic k, input string tag);
      logic fire;
      exp_t e;
      @(negedge clk);
      cfg_we = we; cfg_tmr = t; cfg_cnt = c; frame_done = f; unit_tick = k;
      fire = 1'b0;
      if (we) begin
         m_pt = t; m_pc = c; m_t = t; m_c = c; m_run = 1'b0;
      end else if (f) begin
         if (m_pt == 0 && m_pc == 0) fire = 1'b1;
         if (m_pc != 0) begin
            if (m_c == 1) fire = 1'b1; else m_c = m_c - 3'd1;
         end
         if (m_pt != 0) begin m_t = m_pt; m_run = 1'b1; end
      end else if (k && m_run) begin
         if (m_t == 1) fire = 1'b1; else m_t = m_t - 4'd1;
      end
      if (fire) begin m_t = m_pt; m_c = m_pc; m_run = 1'b0; end
      e.irq = fire; e.tmr = m_t; e.cnt = m_c; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic wr(input logic [3:0] t, input logic [2:0] c, input string tag);
      drive(1'b1, t, c, 1'b0, 1'b0, tag);
   endtask
   task automatic frm(input string tag);  drive(1'b0, 4'd9, 3'd5, 1'b1, 1'b0, tag); endtask
   task automatic tck(input string tag);  drive(1'b0, 4'd9, 3'd5, 1'b0, 1'b1, tag); endtask
   task automatic idl(input string tag);  drive(1'b0, 4'd0, 3'd0, 1'b0, 1'b0, tag); endtask

   // monitor: compare after each edge
   initial begin
      forever begin
         @(posedge clk); #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (irq_set !== e.irq || tmr_live !== e.tmr || cnt_live !== e.cnt) begin
               n_fail++;
               $display("FAIL %s: got irq=%0b tmr=%0d cnt=%0d, expected irq=%0b tmr=%0d cnt=%0d",
                        e.tag, irq_set, tmr_live, cnt_live, e.irq, e.tmr, e.cnt);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_run++;
      if (irq_set !== 1'b0 || tmr_live !== 4'd0 || cnt_live !== 3'd0) begin
         n_fail++;
         $display("FAIL R1: got irq=%0b tmr=%0d cnt=%0d, expected 0 0 0", irq_set, tmr_live, cnt_live);
      end
      rst_n = 1'b1;
      // R1 / R5: defaults disable mitigation
      idl("R1");
      frm("R5"); frm("R5"); idl("R5");
      // R2 write then R3 / R4 count threshold
      wr(4'd0, 3'd3, "R2");
      frm("R3"); idl("R3"); frm("R3"); frm("R4"); idl("R4");
      tck("R8"); tck("R8");
      // timer only: R6 / R7 / R8
      wr(4'd3, 3'd0, "R2");
      tck("R8"); frm("R6"); tck("R7"); idl("R7"); tck("R7"); tck("R7");
      tck("R8"); tck("R8"); idl("R8");
      // R6 reload on a frame while running
      wr(4'd4, 3'd0, "R2");
      frm("R6"); tck("R7"); tck("R7"); frm("R6"); tck("R7");
      // R2 write while running stops the timer and discards a frame
      drive(1'b1, 4'd2, 3'd2, 1'b1, 1'b1, "R2");
      tck("R2"); tck("R2");
      // both enabled: count wins, then both reload (R8)
      frm("R6"); frm("R4"); tck("R8"); tck("R8");
      // both enabled: timer wins
      frm("R3"); tck("R7"); tck("R7"); idl("R8"); frm("R3");
      // R9 frame and tick together
      wr(4'd2, 3'd0, "R2");
      frm("R6"); tck("R7"); drive(1'b0, 4'd0, 3'd0, 1'b1, 1'b1, "R9"); tck("R9"); tck("R9");
      // R10 count of 1 fires on each frame, no pulse after a write
      wr(4'd0, 3'd1, "R10");
      frm("R4"); frm("R4"); idl("R10");
      wr(4'd0, 3'd0, "R10");
      idl("R10");
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule